// File: doc/BRIEF.md
# Masked ADC Channel Scanner

This block decides which analog channel a successive-approximation converter samples next, and it times each conversion. Sixteen channels are enabled by two 8-bit masks. The scanner walks the enabled channels in order of increasing index, wraps from the top back to the bottom, and moves one step after every finished conversion. A conversion can be started from a software register strobe (manual mode) or from a measurement sequencer (sequencer mode). The two modes use different rules for when the channel pointer returns to the lowest enabled channel.

A conversion lasts a fixed 25 converter clock periods plus a programmable number of settling periods. The converter clock is derived from a 1 MHz strobe through a programmable divider. The analog converter itself is replaced by a data input, which is sampled on the last converter clock. The result and its channel index are then offered to the FIFO for one cycle, together with an end-of-conversion interrupt pulse. A live data output follows the data input one cycle late, whether or not a conversion is running.

The controller has four states:
- `ST_IDLE` waits for a trigger.
- `ST_SETTLE` counts the settling periods.
- `ST_CONV` counts the conversion periods.
- `ST_DONE` presents the result for one cycle.

Its transitions are:
- start-with-settle: `ST_IDLE` to `ST_SETTLE`, taken when a trigger is accepted and the settling count is non-zero.
- start-direct: `ST_IDLE` to `ST_CONV`, taken when a trigger is accepted and the settling count is zero.
- settle-complete: `ST_SETTLE` to `ST_CONV`.
- conversion-complete: `ST_CONV` to `ST_DONE`.
- result-retire: `ST_DONE` to `ST_IDLE`, which also advances the pointer.

Top module: `adc_chan_scanner`

## Requirements
- R1: The channel index is the bit position in the 16-bit vector {mask_hi, mask_lo}, so channels 0..7 come from mask_lo and channels 8..15 come from mask_hi. A trigger converts the first enabled channel found when searching upward from cur_chan, inclusive of cur_chan, and wrapping from 15 back to 0.
- R2: In the cycle after fifo_valid, cur_chan holds the next enabled channel above the channel just converted, wrapping from 15 back to 0. If that channel is the only one enabled, cur_chan returns to it.
- R3: In manual mode (seq_mode=0), a cycle with mask_wr=1 sets cur_chan to the lowest enabled channel of the masks present in that cycle. This takes priority over the pointer advance.
- R4: In sequencer mode (seq_mode=1), the first rising edge of seq_run after reset sets cur_chan to the lowest enabled channel. Later restarts of seq_run leave cur_chan unchanged. A mask_wr in this mode leaves cur_chan unchanged.
- R5: A conversion spans settle_cycles + 25 converter ticks. A converter tick occurs on every (clk_div+1)-th tick_1mhz pulse, counted from the cycle after the trigger is accepted. fifo_valid rises in the cycle after the last tick.
- R6: fifo_valid and eoc_irq are high together for exactly one cycle. During that cycle, fifo_data is the value adc_in had at the last converter tick, and fifo_chan is the converted channel.
- R7: live_data equals the value adc_in had one cycle earlier, at all times after reset.
- R8: When both masks are zero, triggers start no conversion: busy stays low and fifo_valid never rises.
- R9: busy is high from the cycle after an accepted trigger through the fifo_valid cycle. A trigger that arrives while busy is high is dropped and is not queued.
- R10: In manual mode only man_trig starts a conversion. In sequencer mode only seq_trig starts a conversion, and only while seq_run is high.
- R11: After reset, busy, fifo_valid and eoc_irq are 0, and cur_chan is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1mhz | input | 1 | One-cycle 1 MHz time-base strobe |
| clk_div | input | 8 | Converter clock divider; one tick per clk_div+1 strobes |
| settle_cycles | input | 8 | Settling periods before the 25 conversion periods |
| mask_lo | input | 8 | Enable bits for channels 0..7 |
| mask_hi | input | 8 | Enable bits for channels 8..15 |
| mask_wr | input | 1 | Strobe marking a write to either mask register |
| seq_mode | input | 1 | Trigger source select: 0 manual, 1 sequencer |
| seq_run | input | 1 | Sequencer running level |
| seq_trig | input | 1 | Sequencer conversion start strobe |
| man_trig | input | 1 | Register-write conversion start strobe |
| adc_in | input | 14 | Stand-in for the converter's digital result |
| busy | output | 1 | Conversion in progress |
| fifo_valid | output | 1 | One-cycle result strobe toward the FIFO |
| fifo_data | output | 14 | Converted sample |
| fifo_chan | output | 4 | Channel index of the sample |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| cur_chan | output | 4 | Current channel pointer |
| live_data | output | 14 | Unlatched view of the converter data |

## Verification
The assertions assume that the masks, the divider and the settling count stay constant while a conversion is in progress. Under that assumption, every reported channel is still an enabled one. The checks also assume that a trigger never coincides with a mask write or with the first start of the sequencer. The stimulus writes masks, switches modes and toggles seq_run only while the block is idle. It pulses triggers only in cycles where none of these other events happens. Triggers issued while busy are still exercised, because dropping them is defined behaviour.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CONV,
        ST_DONE
    } scan_state_e;

    // Converter periods spent on the bit decisions, after settling.
    localparam int CONV_BASE_CYCLES = 25;
endpackage

// File: rtl/adc_chan_pick.sv
// Circular search for the first set mask bit at or after a start index.
module adc_chan_pick #(
    parameter int NCH = 16,
    parameter int IW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [IW-1:0]  start,
    input  logic           inclusive,
    output logic [IW-1:0]  chan
);
    logic [IW-1:0] cand;

    always_comb begin
        chan = '0;
        cand = '0;
        // Walk offsets downward so the nearest hit is the one that remains.
        for (int k = NCH - 1; k >= 0; k--) begin
            cand = start + IW'(k) + IW'(!inclusive);
            if (mask[cand]) begin
                chan = cand;
            end
        end
    end
endmodule

// File: rtl/adc_tick_gen.sv
// Converter clock enable: one tick per (div+1) base strobes while enabled.
module adc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] div,
    output logic             adc_tick
);
    logic [DIV_W-1:0] cnt_q;

    assign adc_tick = en & base_tick & (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && base_tick) begin
            cnt_q <= (cnt_q == div) ? '0 : cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_chan_scanner.sv
module adc_chan_scanner
    import adc_scan_pkg::*;
#(
    parameter int MASK_W   = 8,
    parameter int DATA_W   = 14,
    parameter int DIV_W    = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_1mhz,
    input  logic [DIV_W-1:0]            clk_div,
    input  logic [SETTLE_W-1:0]         settle_cycles,
    input  logic [MASK_W-1:0]           mask_lo,
    input  logic [MASK_W-1:0]           mask_hi,
    input  logic                        mask_wr,
    input  logic                        seq_mode,
    input  logic                        seq_run,
    input  logic                        seq_trig,
    input  logic                        man_trig,
    input  logic [DATA_W-1:0]           adc_in,
    output logic                        busy,
    output logic                        fifo_valid,
    output logic [DATA_W-1:0]           fifo_data,
    output logic [$clog2(2*MASK_W)-1:0] fifo_chan,
    output logic                        eoc_irq,
    output logic [$clog2(2*MASK_W)-1:0] cur_chan,
    output logic [DATA_W-1:0]           live_data
);
    localparam int NCH   = 2 * MASK_W;
    localparam int IW    = $clog2(NCH);
    localparam int CNT_W = (SETTLE_W > 5) ? SETTLE_W : 5;

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IW-1:0]    ptr_q, conv_ch_q;
    logic [DATA_W-1:0] data_q, live_q;
    logic             run_q, started_q;

    logic [NCH-1:0] all_mask;
    logic           any_en, trig_req, trig_go, seq_first;
    logic           adc_tick, tick_en, last_settle, last_conv;
    logic [IW-1:0]  low_ch, sel_ch, nxt_ch;

    assign all_mask  = {mask_hi, mask_lo};
    assign any_en    = |all_mask;
    assign trig_req  = seq_mode ? (seq_trig & seq_run) : man_trig;
    assign trig_go   = (state_q == ST_IDLE) & trig_req & any_en;
    assign seq_first = seq_mode & seq_run & ~run_q & ~started_q;
    assign tick_en   = (state_q == ST_SETTLE) | (state_q == ST_CONV);

    assign last_settle = (cnt_q == CNT_W'(settle_cycles) - CNT_W'(1));
    assign last_conv   = (cnt_q == CNT_W'(CONV_BASE_CYCLES - 1));

    // Lowest enabled channel, used by the pointer reset rules.
    adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick_low (
        .mask(all_mask), .start('0), .inclusive(1'b1), .chan(low_ch)
    );

    // Channel converted by a trigger: pointer itself or the next enabled one.
    adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick_sel (
        .mask(all_mask), .start(ptr_q), .inclusive(1'b1), .chan(sel_ch)
    );

    // Channel after the one just converted.
    adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick_nxt (
        .mask(all_mask), .start(conv_ch_q), .inclusive(1'b0), .chan(nxt_ch)
    );

    adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trig_go),
        .en       (tick_en),
        .base_tick(tick_1mhz),
        .div      (clk_div),
        .adc_tick (adc_tick)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_go) begin
                    state_d = (settle_cycles == '0) ? ST_CONV : ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (adc_tick && last_settle) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (adc_tick && last_conv) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            ptr_q     <= '0;
            conv_ch_q <= '0;
            data_q    <= '0;
            live_q    <= '0;
            run_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            state_q <= state_d;
            live_q  <= adc_in;
            run_q   <= seq_run;

            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (adc_tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end

            if (trig_go) begin
                conv_ch_q <= sel_ch;
            end

            if (state_q == ST_CONV && adc_tick && last_conv) begin
                data_q <= adc_in;
            end

            if (seq_first) begin
                started_q <= 1'b1;
            end

            if (!seq_mode && mask_wr) begin
                ptr_q <= low_ch;
            end else if (state_q == ST_DONE) begin
                ptr_q <= nxt_ch;
            end else if (seq_first) begin
                ptr_q <= low_ch;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        fifo_valid = (state_q == ST_DONE);
        eoc_irq    = (state_q == ST_DONE);
        fifo_data  = data_q;
        fifo_chan  = conv_ch_q;
        cur_chan   = ptr_q;
        live_data  = live_q;
    end
endmodule

// File: rtl/adc_chan_scanner_chk.sv
module adc_chan_scanner_chk #(
    parameter int MASK_W = 8,
    parameter int DATA_W = 14
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [MASK_W-1:0]           mask_lo,
    input logic [MASK_W-1:0]           mask_hi,
    input logic                        seq_mode,
    input logic                        seq_run,
    input logic [DATA_W-1:0]           adc_in,
    input logic                        busy,
    input logic                        fifo_valid,
    input logic                        eoc_irq,
    input logic [$clog2(2*MASK_W)-1:0] fifo_chan,
    input logic [$clog2(2*MASK_W)-1:0] cur_chan,
    input logic [DATA_W-1:0]           live_data
);
    logic [2*MASK_W-1:0] all_mask;
    assign all_mask = {mask_hi, mask_lo};

    assert_chan_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid |-> all_mask[fifo_chan]);

    assert_hold_in_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && !busy && !seq_run) |=> $stable(cur_chan));

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_valid) |-> $past(busy));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid |=> !fifo_valid);

    assert_eoc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    assert_live_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live_data == $past(adc_in)));

    assert_no_start_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (all_mask == '0 && !busy) |=> !busy);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fifo_valid) |=> busy);
endmodule

bind adc_chan_scanner adc_chan_scanner_chk #(.MASK_W(MASK_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .seq_mode  (seq_mode),
    .seq_run   (seq_run),
    .adc_in    (adc_in),
    .busy      (busy),
    .fifo_valid(fifo_valid),
    .eoc_irq   (eoc_irq),
    .fifo_chan (fifo_chan),
    .cur_chan  (cur_chan),
    .live_data (live_data)
);

// File: tb/tb_adc_chan_scanner.sv
module tb_adc_chan_scanner;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1mhz = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic [7:0]  settle_cycles = 8'd2;
    logic [7:0]  mask_lo = 8'd0, mask_hi = 8'd0;
    logic        mask_wr = 1'b0, seq_mode = 1'b0, seq_run = 1'b0;
    logic        seq_trig = 1'b0, man_trig = 1'b0;
    logic [13:0] adc_in = 14'd5;
    logic        busy, fifo_valid, eoc_irq;
    logic [13:0] fifo_data, live_data;
    logic [3:0]  fifo_chan, cur_chan;

    always #2.5 clk = ~clk;

    adc_chan_scanner dut (
        .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_1mhz), .clk_div(clk_div),
        .settle_cycles(settle_cycles), .mask_lo(mask_lo), .mask_hi(mask_hi),
        .mask_wr(mask_wr), .seq_mode(seq_mode), .seq_run(seq_run),
        .seq_trig(seq_trig), .man_trig(man_trig), .adc_in(adc_in),
        .busy(busy), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_chan(fifo_chan), .eoc_irq(eoc_irq), .cur_chan(cur_chan),
        .live_data(live_data)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int tick_per = 1, tcnt = 0;
    int chan_log[$];

    task automatic chk(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Time base and converter data source.
    always @(posedge clk) begin
        if (tcnt >= tick_per - 1) begin
            tcnt <= 0;
            tick_1mhz <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick_1mhz <= 1'b0;
        end
        adc_in <= adc_in + 14'd37;
    end

    // Reference model: phase 0 idle, 1 converting, 2 result cycle.
    int m_phase = 0, m_left = 0, m_divc = 0, m_ptr = 0, m_conv = 0;
    int m_chan = 0, m_data = 0, m_live = 0;
    bit m_started = 0, m_prev_run = 0;

    function automatic int mdl_pick(int start, bit incl);
        logic [15:0] m;
        m = {mask_hi, mask_lo};
        for (int k = 0; k < NCH; k++) begin
            int c;
            c = (start + k + (incl ? 0 : 1)) % NCH;
            if (m[c]) return c;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_divc = 0; m_ptr = 0; m_conv = 0;
            m_chan = 0; m_data = 0; m_live = 0; m_started = 0; m_prev_run = 0;
        end else begin
            int  n_ptr;
            bit  first, trig;
            first = seq_mode && seq_run && !m_prev_run && !m_started;
            trig  = seq_mode ? (seq_trig && seq_run) : man_trig;
            n_ptr = m_ptr;
            if (!seq_mode && mask_wr) n_ptr = mdl_pick(0, 1);
            else if (m_phase == 2) n_ptr = mdl_pick(m_conv, 0);
            else if (first) n_ptr = mdl_pick(0, 1);
            if (m_phase == 2) begin
                m_phase = 0;
            end else if (m_phase == 1) begin
                if (tick_1mhz) begin
                    if (m_divc == int'(clk_div)) begin
                        m_divc = 0;
                        m_left--;
                        if (m_left == 0) begin
                            m_phase = 2;
                            m_data = adc_in;
                            m_chan = m_conv;
                        end
                    end else begin
                        m_divc++;
                    end
                end
            end else if (trig && {mask_hi, mask_lo} != 16'd0) begin
                m_phase = 1;
                m_left = int'(settle_cycles) + 25;
                m_divc = 0;
                m_conv = mdl_pick(m_ptr, 1);
            end
            if (first) m_started = 1;
            m_prev_run = seq_run;
            m_ptr = n_ptr;
            m_live = adc_in;
        end
    end

    // Cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", busy, m_phase != 0, "busy");
            chk("R5", fifo_valid, m_phase == 2, "fifo_valid");
            chk("R6", eoc_irq, m_phase == 2, "eoc_irq");
            chk("R2", cur_chan, m_ptr, "cur_chan");
            chk("R7", live_data, m_live, "live_data");
            if (m_phase == 2) begin
                chk("R6", fifo_data, m_data, "fifo_data");
                chk("R1", fifo_chan, m_chan, "fifo_chan");
            end
            if (fifo_valid) chan_log.push_back(fifo_chan);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_mask(logic [7:0] lo, logic [7:0] hi);
        mask_lo = lo; mask_hi = hi; mask_wr = 1'b1;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic pulse_man();
        man_trig = 1'b1; step(); man_trig = 1'b0;
    endtask

    task automatic pulse_seq();
        seq_trig = 1'b1; step(); seq_trig = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) step();
        step();
    endtask

    task automatic measure(string req, int exp);
        int k;
        man_trig = 1'b1; step(); man_trig = 1'b0;
        k = 1;
        do begin
            @(negedge clk); k++;
        end while (!fifo_valid && k < 5000);
        chk(req, k, exp, "conversion length");
        step();
        wait_idle();
    endtask

    task automatic chk_log(string req, int exp[$]);
        chk(req, chan_log.size(), exp.size(), "conversion count");
        for (int i = 0; i < exp.size() && i < chan_log.size(); i++)
            chk(req, chan_log[i], exp[i], "scan order");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int sz;
        logic [13:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11", busy, 0, "busy after reset");
        chk("R11", fifo_valid, 0, "valid after reset");
        chk("R11", eoc_irq, 0, "irq after reset");
        chk("R11", cur_chan, 0, "pointer after reset");
        step();

        // Manual scan across both masks with wrap.
        wr_mask(8'h92, 8'h05);
        @(negedge clk);
        chk("R3", cur_chan, 1, "pointer after mask write");
        step();
        chan_log.delete();
        repeat (6) begin pulse_man(); wait_idle(); end
        chk_log("R1", '{1, 4, 7, 8, 10, 1});
        @(negedge clk);
        chk("R2", cur_chan, 4, "pointer after wrap");
        step();

        // Mask write resets pointer in manual mode.
        wr_mask(8'h90, 8'h05);
        @(negedge clk);
        chk("R3", cur_chan, 4, "pointer to lowest");
        step();

        // Conversion lengths.
        settle_cycles = 8'd0; clk_div = 8'd0;
        measure("R5", 27);
        settle_cycles = 8'd64; clk_div = 8'd1;
        measure("R5", 180);
        settle_cycles = 8'd3; clk_div = 8'd2;
        measure("R5", 86);

        // Trigger during busy is dropped.
        settle_cycles = 8'd2; clk_div = 8'd0;
        sz = chan_log.size();
        pulse_man();
        repeat (5) step();
        pulse_man();
        wait_idle();
        repeat (3) begin
            @(negedge clk);
            chk("R9", busy, 0, "busy after dropped trigger");
        end
        chk("R9", chan_log.size() - sz, 1, "conversions after double trigger");
        step();

        // Slower time base.
        tick_per = 3; clk_div = 8'd1;
        repeat (3) begin pulse_man(); wait_idle(); end
        tick_per = 1; clk_div = 8'd0;
        repeat (4) step();

        // Empty masks ignore triggers.
        wr_mask(8'h00, 8'h00);
        sz = chan_log.size();
        pulse_man();
        repeat (4) begin
            @(negedge clk);
            chk("R8", busy, 0, "busy with empty masks");
        end
        chk("R8", chan_log.size(), sz, "no result with empty masks");
        step();

        // Live data view.
        @(negedge clk); v = adc_in;
        @(negedge clk);
        chk("R7", live_data, v, "live data lag");
        step();

        // Sequencer mode.
        wr_mask(8'h06, 8'h80);
        pulse_man(); wait_idle();
        @(negedge clk);
        chk("R2", cur_chan, 2, "pointer before sequencer");
        step();
        seq_mode = 1'b1;
        step();
        wr_mask(8'h07, 8'h80);
        @(negedge clk);
        chk("R4", cur_chan, 2, "mask write in sequencer mode");
        step();
        pulse_man();
        @(negedge clk);
        chk("R10", busy, 0, "manual trigger in sequencer mode");
        step();
        pulse_seq();
        @(negedge clk);
        chk("R10", busy, 0, "sequencer trigger while stopped");
        step();
        seq_run = 1'b1;
        step();
        @(negedge clk);
        chk("R4", cur_chan, 0, "first sequencer start");
        step();
        chan_log.delete();
        repeat (2) begin pulse_seq(); wait_idle(); end
        seq_run = 1'b0;
        repeat (3) step();
        seq_run = 1'b1;
        repeat (2) step();
        @(negedge clk);
        chk("R4", cur_chan, 2, "pointer kept across restart");
        step();
        repeat (2) begin pulse_seq(); wait_idle(); end
        chk_log("R1", '{0, 1, 2, 15});
        repeat (4) step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule